// File: doc/BRIEF.md
# Line and Field Sync Timer for a Composite Video Encoder

This block sets the line and field rhythm of a composite video encoder pipeline. In master mode it times itself. After reset it waits a fixed lead-in, then drives an active-low horizontal sync output. It repeats lines at a programmed length in pixel clocks. In slave mode it follows an external active-low line sync. A falling edge that comes early cuts the current line short and starts a new one. An edge that comes late holds the block in a stretched front porch until it arrives.

Each line start is also sent down a fixed delay line. The delay produces a one-cycle sync strobe that lines up with the sync edge leaving the composite output pipeline. A standard-select input chooses between 525-line and 625-line counting. A line number and a field number follow every line start. The first line after reset is numbered the way each standard numbers the frame's first sync.

Top module: `video_sync_timer`

## Requirements
- R1: While `rst` is high, and in the cycle after any clock edge that samples it high, `hsync_n_o`=1, `sync_strb_o`=0, `porch_ext_o`=0, `line_o`=0 and `field_o`=0. Reset also clears any strobe still in the delay line.
- R2: Master mode (`slave_i`=0). Count the rising edges at which `rst` is sampled low, starting at 1. `hsync_n_o` is 0 after edges 18 through 17+`hs_width_i` and 1 after every other edge in that span.
- R3: Master mode. Each later fall of `hsync_n_o` comes exactly `line_len_i` cycles after the one before it. The low time is `hs_width_i` cycles every line.
- R4: Master mode. `sync_strb_o` is high for exactly one cycle, 38 edges after each fall of `hsync_n_o`. For the first line this is after edge 56.
- R5: On the first line start after reset, `line_o` becomes 4 when `std_i`=0 (525-line counting) or 1 when `std_i`=1 (625-line counting). `field_o` becomes 1.
- R6: At every later line start, `line_o` goes up by one and wraps from 525 (`std_i`=0) or 625 (`std_i`=1) back to 1. `field_o` is 2 when the new line is at least 264 (`std_i`=0) or 314 (`std_i`=1), and 1 otherwise. Both change at the same edge as the master `hsync_n_o` fall.
- R7: Slave mode (`slave_i`=1). `hs_in_n` passes through a two-stage synchronizer. If the first low level of `hs_in_n` is sampled at edge A, the line starts at edge A+2, where `line_o` updates. `sync_strb_o` pulses after edge A+46. `hsync_n_o` stays 1.
- R8: Slave mode. A falling edge that arrives before the programmed line has run out restarts the line at once. The line counter advances, no porch stretch occurs, and the 46-cycle strobe delay still holds.
- R9: Slave mode. If the line runs out before the next falling edge, `porch_ext_o` is 1 in every cycle until the line start. Two falls sampled g edges apart, with g above `line_len_i`, give exactly g−`line_len_i` high cycles. A gap equal to `line_len_i` gives none.
- R10: Slave mode. Before the first falling edge after reset, there is no strobe, `porch_ext_o` stays 0 and `line_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_i | input | 1 | 1 = follow `hs_in_n`, 0 = self-timed |
| std_i | input | 1 | 0 = 525-line counting, 1 = 625-line counting |
| line_len_i | input | PIX_W | Pixel clocks per line |
| hs_width_i | input | HSW_W | Sync low time in master mode, in pixel clocks |
| hs_in_n | input | 1 | External active-low line sync (slave mode) |
| hsync_n_o | output | 1 | Active-low horizontal sync driven in master mode |
| sync_strb_o | output | 1 | One-cycle strobe aligned to the output sync edge |
| line_o | output | LINE_W | Current line number, 0 before the first line |
| field_o | output | FIELD_W | Current field (1 or 2), 0 before the first line |
| porch_ext_o | output | 1 | High while a line is stretched waiting for a late sync |

## Verification
The assertions rely on these conditions:
- `slave_i` and `std_i` change only while `rst` is high.
- `line_len_i` is at least 2 and larger than `hs_width_i`, and `hs_width_i` is at least 1.
- Each low pulse on `hs_in_n` is followed by a high level, so two detected falls are at least two cycles apart.
- Reset is held for at least two edges.

The stimulus changes configuration only inside reset. It holds every external sync low for four cycles, and keeps falls at least twelve cycles apart. That covers on-time, early and late arrivals without breaking those conditions.

// File: rtl/vst_pkg.sv
package vst_pkg;

  typedef enum logic [1:0] {
    ST_LEAD,
    ST_IDLE,
    ST_LINE,
    ST_PORCH
  } vst_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vst_fall_detect.sv
module vst_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in_n,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // idle level of the sync line is high, so reset to ones (no false edge)
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q[0] <= line_in_n;
      for (int i = 1; i < STAGES; i++) begin
        sync_q[i] <= sync_q[i-1];
      end
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/vst_line_fsm.sv
module vst_line_fsm
  import vst_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int HSW_W    = 8,
  parameter int LEAD_CYC = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slave_i,
  input  logic [PIX_W-1:0] line_len_i,
  input  logic [HSW_W-1:0] hs_width_i,
  input  logic             ext_fall_i,
  output logic             line_start_o,
  output logic             hsync_n_o,
  output logic             porch_o
);

  localparam int LEAD_W = $clog2(LEAD_CYC + 1);
  localparam logic [LEAD_W-1:0] LEAD_LAST = LEAD_W'(LEAD_CYC - 1);

  vst_state_e        state_q, state_d;
  logic [PIX_W-1:0]  pix_q, pix_d;
  logic [LEAD_W-1:0] lead_q, lead_d;
  logic [PIX_W-1:0]  last_pix;
  logic              start;
  logic              hs_low_d;
  logic              hs_n_q;
  logic              porch_q;

  assign last_pix = line_len_i - PIX_W'(1);

  always_comb begin
    state_d = state_q;
    pix_d   = pix_q;
    lead_d  = lead_q;
    start   = 1'b0;
    case (state_q)
      ST_LEAD: begin
        if (slave_i) begin
          if (ext_fall_i) start = 1'b1;
          else            state_d = ST_IDLE;
        end else if (lead_q == LEAD_LAST) begin
          start = 1'b1;
        end else begin
          lead_d = lead_q + LEAD_W'(1);
        end
      end
      ST_IDLE: begin
        if (slave_i && ext_fall_i) start = 1'b1;
      end
      ST_LINE: begin
        if (slave_i && ext_fall_i) begin
          start = 1'b1;                 // early (or on-time) external sync
        end else if (pix_q == last_pix) begin
          if (slave_i) state_d = ST_PORCH;
          else         start   = 1'b1;
        end else begin
          pix_d = pix_q + PIX_W'(1);
        end
      end
      ST_PORCH: begin
        if (ext_fall_i) start = 1'b1;
      end
      default: state_d = ST_LEAD;
    endcase
    if (start) begin
      state_d = ST_LINE;
      pix_d   = '0;
    end
  end

  assign hs_low_d = !slave_i && (state_d == ST_LINE) && (pix_d < PIX_W'(hs_width_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_LEAD;
      pix_q   <= '0;
      lead_q  <= '0;
      hs_n_q  <= 1'b1;
      porch_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pix_q   <= pix_d;
      lead_q  <= lead_d;
      hs_n_q  <= ~hs_low_d;
      porch_q <= (state_d == ST_PORCH);
    end
  end

  assign line_start_o = start;
  assign hsync_n_o    = hs_n_q;
  assign porch_o      = porch_q;

endmodule

// File: rtl/vst_line_count.sv
module vst_line_count #(
  parameter int LINE_W  = 10,
  parameter int FIELD_W = 2,
  parameter int LINES_A = 525,
  parameter int LINES_B = 625,
  parameter int F2_A    = 264,
  parameter int F2_B    = 314,
  parameter int FIRST_A = 4,
  parameter int FIRST_B = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               std_i,
  input  logic               start_i,
  output logic [LINE_W-1:0]  line_o,
  output logic [FIELD_W-1:0] field_o
);

  localparam logic [LINE_W-1:0]  TOT_A  = LINE_W'(LINES_A);
  localparam logic [LINE_W-1:0]  TOT_B  = LINE_W'(LINES_B);
  localparam logic [LINE_W-1:0]  SEC_A  = LINE_W'(F2_A);
  localparam logic [LINE_W-1:0]  SEC_B  = LINE_W'(F2_B);
  localparam logic [LINE_W-1:0]  INIT_A = LINE_W'(FIRST_A);
  localparam logic [LINE_W-1:0]  INIT_B = LINE_W'(FIRST_B);
  localparam logic [FIELD_W-1:0] FLD1   = FIELD_W'(1);
  localparam logic [FIELD_W-1:0] FLD2   = FIELD_W'(2);

  logic [LINE_W-1:0]  line_q, line_nxt;
  logic [LINE_W-1:0]  total, sec_start, init_line;
  logic [FIELD_W-1:0] field_q;
  logic               first_q;

  assign total     = std_i ? TOT_B  : TOT_A;
  assign sec_start = std_i ? SEC_B  : SEC_A;
  assign init_line = std_i ? INIT_B : INIT_A;

  always_comb begin
    if (first_q)              line_nxt = init_line;
    else if (line_q == total) line_nxt = LINE_W'(1);
    else                      line_nxt = line_q + LINE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= '0;
      field_q <= '0;
      first_q <= 1'b1;
    end else if (start_i) begin
      line_q  <= line_nxt;
      field_q <= (line_nxt >= sec_start) ? FLD2 : FLD1;
      first_q <= 1'b0;
    end
  end

  assign line_o  = line_q;
  assign field_o = field_q;

endmodule

// File: rtl/vst_strobe_delay.sv
module vst_strobe_delay
  import vst_pkg::*;
#(
  parameter int MST_TAP = 37,
  parameter int SLV_TAP = 43
) (
  input  logic clk,
  input  logic rst,
  input  logic slave_i,
  input  logic start_i,
  output logic strobe_o
);

  localparam int SR_LEN = int'(max2(MST_TAP, SLV_TAP)) + 1;

  logic [SR_LEN-1:0] sr_q;
  logic              tap;
  logic              strb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else begin
      sr_q[0] <= start_i;
      for (int i = 1; i < SR_LEN; i++) begin
        sr_q[i] <= sr_q[i-1];
      end
    end
  end

  generate
    if (MST_TAP == SLV_TAP) begin : g_one_tap
      assign tap = sr_q[MST_TAP];
    end else begin : g_two_tap
      assign tap = slave_i ? sr_q[SLV_TAP] : sr_q[MST_TAP];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) strb_q <= 1'b0;
    else     strb_q <= tap;
  end

  assign strobe_o = strb_q;

endmodule

// File: rtl/video_sync_timer.sv
module video_sync_timer #(
  parameter int PIX_W       = 12,
  parameter int HSW_W       = 8,
  parameter int LINE_W      = 10,
  parameter int FIELD_W     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int LEAD_CYC    = 18,
  parameter int MST_LAT     = 38,
  parameter int SLV_LAT     = 46,
  parameter int LINES_A     = 525,
  parameter int LINES_B     = 625,
  parameter int F2_A        = 264,
  parameter int F2_B        = 314,
  parameter int FIRST_A     = 4,
  parameter int FIRST_B     = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slave_i,
  input  logic               std_i,
  input  logic [PIX_W-1:0]   line_len_i,
  input  logic [HSW_W-1:0]   hs_width_i,
  input  logic               hs_in_n,
  output logic               hsync_n_o,
  output logic               sync_strb_o,
  output logic [LINE_W-1:0]  line_o,
  output logic [FIELD_W-1:0] field_o,
  output logic               porch_ext_o
);

  // tap positions: stage 0 loads with the line start; one output register follows
  localparam int MST_TAP = MST_LAT - 1;
  localparam int SLV_TAP = SLV_LAT - SYNC_STAGES - 1;

  logic ext_fall;
  logic line_start;

  vst_fall_detect #(
    .STAGES(SYNC_STAGES)
  ) u_fall (
    .clk      (clk),
    .rst      (rst),
    .line_in_n(hs_in_n),
    .fall_o   (ext_fall)
  );

  vst_line_fsm #(
    .PIX_W   (PIX_W),
    .HSW_W   (HSW_W),
    .LEAD_CYC(LEAD_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .slave_i     (slave_i),
    .line_len_i  (line_len_i),
    .hs_width_i  (hs_width_i),
    .ext_fall_i  (ext_fall),
    .line_start_o(line_start),
    .hsync_n_o   (hsync_n_o),
    .porch_o     (porch_ext_o)
  );

  vst_line_count #(
    .LINE_W (LINE_W),
    .FIELD_W(FIELD_W),
    .LINES_A(LINES_A),
    .LINES_B(LINES_B),
    .F2_A   (F2_A),
    .F2_B   (F2_B),
    .FIRST_A(FIRST_A),
    .FIRST_B(FIRST_B)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .std_i  (std_i),
    .start_i(line_start),
    .line_o (line_o),
    .field_o(field_o)
  );

  vst_strobe_delay #(
    .MST_TAP(MST_TAP),
    .SLV_TAP(SLV_TAP)
  ) u_dly (
    .clk     (clk),
    .rst     (rst),
    .slave_i (slave_i),
    .start_i (line_start),
    .strobe_o(sync_strb_o)
  );

endmodule

// File: rtl/video_sync_timer_chk.sv
module video_sync_timer_chk #(
  parameter int LINE_W  = 10,
  parameter int FIELD_W = 2,
  parameter int LINES_A = 525,
  parameter int LINES_B = 625,
  parameter int FIRST_A = 4,
  parameter int FIRST_B = 1
) (
  input logic               clk,
  input logic               rst,
  input logic               slave_i,
  input logic               std_i,
  input logic               hsync_n_o,
  input logic               sync_strb_o,
  input logic [LINE_W-1:0]  line_o,
  input logic [FIELD_W-1:0] field_o,
  input logic               porch_ext_o
);

  localparam logic [LINE_W-1:0]  TOT_A  = LINE_W'(LINES_A);
  localparam logic [LINE_W-1:0]  TOT_B  = LINE_W'(LINES_B);
  localparam logic [LINE_W-1:0]  INIT_A = LINE_W'(FIRST_A);
  localparam logic [LINE_W-1:0]  INIT_B = LINE_W'(FIRST_B);

  p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    sync_strb_o |=> !sync_strb_o);

  p_porch_only_slave_r9: assert property (@(posedge clk) disable iff (rst)
    porch_ext_o |-> slave_i);

  p_porch_exit_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(porch_ext_o) |-> (line_o != $past(line_o)));

  p_hs_idle_slave_r7: assert property (@(posedge clk) disable iff (rst)
    slave_i |-> hsync_n_o);

  p_first_line_r5: assert property (@(posedge clk) disable iff (rst)
    ((line_o != '0) && ($past(line_o) == '0)) |->
      ((line_o == (std_i ? INIT_B : INIT_A)) && (field_o == FIELD_W'(1))));

  p_line_step_r6: assert property (@(posedge clk) disable iff (rst)
    ((line_o != $past(line_o)) && ($past(line_o) != '0)) |->
      ((line_o == $past(line_o) + LINE_W'(1)) || (line_o == LINE_W'(1))));

  p_hs_fall_line_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n_o) |-> (line_o != $past(line_o)));

  p_bounds_r6: assert property (@(posedge clk) disable iff (rst)
    (field_o <= FIELD_W'(2)) && (line_o <= (std_i ? TOT_B : TOT_A)));

endmodule

bind video_sync_timer video_sync_timer_chk #(
  .LINE_W (LINE_W),
  .FIELD_W(FIELD_W),
  .LINES_A(LINES_A),
  .LINES_B(LINES_B),
  .FIRST_A(FIRST_A),
  .FIRST_B(FIRST_B)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .slave_i    (slave_i),
  .std_i      (std_i),
  .hsync_n_o  (hsync_n_o),
  .sync_strb_o(sync_strb_o),
  .line_o     (line_o),
  .field_o    (field_o),
  .porch_ext_o(porch_ext_o)
);

// File: tb/test_video_sync_timer.sv
module test_video_sync_timer;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 150000;
  localparam int SLV_LEN    = 30;
  localparam int N_VEC      = 7;
  // each row: cycles since previous external fall, expected porch-stretch cycles
  localparam int SLV_TBL [N_VEC][2] = '{
    '{30, 0}, '{20, 0}, '{45, 15}, '{30, 0}, '{12, 0}, '{38, 8}, '{31, 1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slave = 1'b0;
  logic        std = 1'b0;
  logic [11:0] line_len = 12'd24;
  logic [7:0]  hs_w = 8'd4;
  logic        hs_in_n = 1'b1;
  logic        hsync_n_o, sync_strb_o, porch_ext_o;
  logic [9:0]  line_o;
  logic [1:0]  field_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int t0 = 0;
  int fp_cnt = 0;
  int fp_snap = 0;
  bit mon_en = 1'b0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  video_sync_timer i_video_sync_timer (
    .clk(clk), .rst(rst), .slave_i(slave), .std_i(std),
    .line_len_i(line_len), .hs_width_i(hs_w), .hs_in_n(hs_in_n),
    .hsync_n_o(hsync_n_o), .sync_strb_o(sync_strb_o), .line_o(line_o),
    .field_o(field_o), .porch_ext_o(porch_ext_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // strobe timing (R4 master, R7/R8 slave) and porch counting
  always @(negedge clk) begin
    if (mon_en) begin
      if (porch_ext_o) fp_cnt++;
      if (sync_strb_o) begin
        if (exp_q.size() > 0 && exp_q[0] == cyc) begin
          chk(1'b1, slave ? "R7" : "R4", cyc, cyc);
          void'(exp_q.pop_front());
        end else begin
          chk(1'b0, slave ? "R7 unexpected strobe" : "R4 unexpected strobe",
              cyc, (exp_q.size() > 0) ? exp_q[0] : -1);
        end
      end else if (exp_q.size() > 0 && exp_q[0] <= cyc) begin
        chk(1'b0, slave ? "R7 missing strobe" : "R4 missing strobe", cyc, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic do_reset(input bit sl, input bit sd, input int len, input int w);
    @(negedge clk);
    mon_en = 1'b0;
    exp_q.delete();
    rst = 1'b1; slave = sl; std = sd;
    line_len = 12'(len); hs_w = 8'(w); hs_in_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(hsync_n_o == 1'b1 && sync_strb_o == 1'b0 && porch_ext_o == 1'b0, "R1 outputs idle",
        {hsync_n_o, sync_strb_o, porch_ext_o}, 3'b100);
    chk(line_o == 0 && field_o == 0, "R1 counters zero", int'(line_o), 0);
    rst = 1'b0;
    t0 = cyc;
    fp_cnt = 0;
    fp_snap = 0;
    mon_en = 1'b1;
  endtask

  task automatic run_master(input bit sd, input int len, input int w, input int nstarts);
    int first, total, f2, j, hs_bad, bad_at, exp_line, exp_field;
    bit prev, exp_hs;
    do_reset(1'b0, sd, len, w);
    for (int k = 0; k < nstarts; k++) exp_q.push_back(t0 + 56 + k * len);
    first = sd ? 1 : 4;
    total = sd ? 625 : 525;
    f2 = sd ? 314 : 264;
    j = 0; hs_bad = 0; bad_at = 0; prev = 1'b1;
    for (int n = 1; n <= 18 + (nstarts - 1) * len + 2; n++) begin
      @(negedge clk);
      if (n <= 18 + w + 2) begin
        exp_hs = !(n >= 18 && n < 18 + w);
        if (hsync_n_o != exp_hs) begin hs_bad++; bad_at = n; end
      end
      if (prev && !hsync_n_o) begin
        chk(n == 18 + j * len, (j == 0) ? "R2 first fall" : "R3 line period", n, 18 + j * len);
        exp_line = ((first - 1 + j) % total) + 1;
        exp_field = (exp_line >= f2) ? 2 : 1;
        chk(int'(line_o) == exp_line, (j == 0) ? "R5 first line" : "R6 line", int'(line_o), exp_line);
        chk(int'(field_o) == exp_field, (j == 0) ? "R5 first field" : "R6 field", int'(field_o), exp_field);
        j++;
      end
      prev = hsync_n_o;
    end
    chk(hs_bad == 0, "R2 hsync low window", bad_at, 0);
    chk(j == nstarts, "R3 line count", j, nstarts);
    repeat (45) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all strobes seen", exp_q.size(), 0);
  endtask

  task automatic slave_fall(input int exp_fp, input int exp_line, input string req);
    int c;
    c = cyc;
    hs_in_n = 1'b0;
    exp_q.push_back(c + 47);
    repeat (3) @(negedge clk);
    chk(int'(line_o) == exp_line, req, int'(line_o), exp_line);
    chk(fp_cnt - fp_snap == exp_fp, "R9 porch cycles", fp_cnt - fp_snap, exp_fp);
    chk(hsync_n_o == 1'b1, "R7 hsync idle in slave", hsync_n_o, 1);
    fp_snap = fp_cnt;
    @(negedge clk);
    hs_in_n = 1'b1;
  endtask

  initial begin
    // R1 from power-up
    repeat (2) @(negedge clk);
    chk(hsync_n_o == 1'b1 && sync_strb_o == 1'b0 && porch_ext_o == 1'b0, "R1 power-up",
        {hsync_n_o, sync_strb_o, porch_ext_o}, 3'b100);

    // master: short run with unusual width, then full frames in both standards
    run_master(1'b0, 40, 7, 3);
    run_master(1'b0, 24, 4, 524);
    run_master(1'b1, 24, 5, 627);

    // slave: idle before first sync (R10)
    do_reset(1'b1, 1'b0, SLV_LEN, 4);
    repeat (60) @(negedge clk);
    chk(line_o == 0 && field_o == 0, "R10 no line before sync", int'(line_o), 0);
    chk(fp_cnt == 0, "R10 no porch before sync", fp_cnt, 0);
    chk(exp_q.size() == 0 && hsync_n_o == 1'b1, "R10 idle", int'(hsync_n_o), 1);

    // slave vector table: on-time, early (R8) and late (R9) arrivals
    slave_fall(0, 4, "R5 slave first line");
    for (int i = 0; i < N_VEC; i++) begin
      repeat (SLV_TBL[i][0] - 4) @(negedge clk);
      slave_fall(SLV_TBL[i][1], 5 + i,
                 (SLV_TBL[i][0] < SLV_LEN) ? "R8 early restart" :
                 (SLV_TBL[i][0] > SLV_LEN) ? "R9 late line" : "R7 on-time line");
    end
    repeat (60) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all slave strobes seen", exp_q.size(), 0);

    // still no sync: line is stretched (R9); reset clears everything (R1)
    chk(porch_ext_o == 1'b1, "R9 stretch while waiting", porch_ext_o, 1);
    mon_en = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk(porch_ext_o == 1'b0 && sync_strb_o == 1'b0 && hsync_n_o == 1'b1, "R1 reset mid-porch",
        {hsync_n_o, sync_strb_o, porch_ext_o}, 3'b100);
    chk(line_o == 0 && field_o == 0, "R1 reset clears counters", int'(line_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=finish before limit", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule